// File: doc/BRIEF.md
# Serial CRC-3 Generator and Checker

This unit divides a serial bit stream, most significant bit first, by the modulo-2 divisor 1011 (x^3 + x + 1) and keeps the 3-bit remainder. A shift register with feedback taps set by the polynomial does the division at one bit per accepted cycle. The result is the same as long division with the stream padded by three zero bits. In generate mode the host feeds a 14-bit message. When the last bit is accepted, the register holds the three check bits that go after that message.

In check mode the host feeds a whole 17-bit frame: the 14 message bits and then the 3 check bits. The frame is good only if the remainder at the end is zero, and the pass flag shows this. A start pulse clears the unit and samples the mode for the next frame. The host may leave gaps in the valid strobe between bits.

Top module: `crc3_serial_unit`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `crc_out` is 000 and `done` and `pass` are low.
- R2: In generate mode (`mode` = 0), after each accepted bit `crc_out` equals the remainder of the bits accepted so far, followed by three zeros, divided modulo 2 by 1011. For the message 11010011101100 the final value is 100.
- R3: A `start` pulse clears the remainder, the bit count and `done`, and latches `mode` (0 = generate, 1 = check). The unit ignores `mode` in every other cycle.
- R4: A cycle with `in_valid` low and `start` low leaves `crc_out`, `done` and `pass` unchanged.
- R5: `done` rises in the cycle after exactly 14 accepted bits in generate mode, or exactly 17 in check mode. It stays high until the next start or reset.
- R6: Bits presented with `in_valid` high while `done` is high are discarded and leave `crc_out` unchanged.
- R7: In check mode, a frame made of a message followed by its own three check bits ends with `crc_out` = 000 and `pass` high.
- R8: `pass` is high only when `done` is high, the latched mode is check, and `crc_out` is 000. It is never high in generate mode.
- R9: If `start` and `in_valid` are high in the same cycle, start wins. The bit is discarded and the count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear pulse; samples the mode |
| mode | input | 1 | 0 = generate, 1 = check (sampled on start) |
| in_valid | input | 1 | Strobe that qualifies `in_bit` |
| in_bit | input | 1 | Serial data, MSB first |
| crc_out | output | 3 | Running remainder |
| done | output | 1 | Frame length reached |
| pass | output | 1 | Check-mode frame has a zero remainder |

## Verification
Two events can fall in the same cycle: a clear from `start` and a bit shift from `in_valid`. The bench provokes this in the middle of a frame by raising `start` and `in_valid` together with a one on `in_bit`. The bench judges the next cycle. It expects a zero remainder and a zero count, and it also expects that `done` arrives only after a full count of bits that follow. A second case drives bits after `done`, so that the end-of-frame limit and new data meet in one cycle. Here the bench expects the remainder to stay unchanged.

// File: rtl/crc3_pkg.sv
package crc3_pkg;

    localparam int CRC_W      = 3;
    localparam int MSG_BITS   = 14;
    localparam int FRAME_BITS = MSG_BITS + CRC_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // x^3 + x + 1 : low-order taps of the generator
    localparam logic [CRC_W-1:0] POLY_TAPS = 3'b011;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;

    typedef struct packed {
        logic             valid;
        logic             data;
    } serial_bit_t;

    // One MSB-first division step: feedback is top bit XOR input bit
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             din
    );
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? POLY_TAPS : '0);
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(input crc_mode_e m);
        return (m == MODE_CHK) ? CNT_W'(FRAME_BITS) : CNT_W'(MSG_BITS);
    endfunction

endpackage

// File: rtl/crc3_lfsr.sv
module crc3_lfsr
    import crc3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [CRC_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= '0;
        end else if (shift_en) begin
            state <= crc_step(state, din);
        end
    end

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(state));

    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clear |=> (state == '0));

endmodule

// File: rtl/crc3_frame_counter.sv
module crc3_frame_counter
    import crc3_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      bit_in,
    input  crc_mode_e mode_q,
    output logic      done
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;

    assign limit = frame_len(mode_q);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            done  <= 1'b0;
        end else if (bit_in && !done) begin
            count <= count + 1'b1;
            if (count == limit - 1'b1) begin
                done <= 1'b1;
            end
        end
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= limit);

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> done);

    a_r5_done_at_limit: assert property (@(posedge clk) disable iff (rst)
        done |-> (count == limit));

endmodule

// File: rtl/crc3_serial_unit.sv
module crc3_serial_unit
    import crc3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic [CRC_W-1:0] crc_out,
    output logic             done,
    output logic             pass
);

    crc_mode_e   mode_q;
    serial_bit_t sbit;
    logic        accept;

    assign sbit.valid = in_valid;
    assign sbit.data  = in_bit;

    // start has priority over a coincident bit (R9)
    assign accept = sbit.valid && !start && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_GEN;
        end else if (start) begin
            mode_q <= crc_mode_e'(mode);
        end
    end

    crc3_lfsr u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .shift_en (accept),
        .din      (sbit.data),
        .state    (crc_out)
    );

    crc3_frame_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .bit_in (accept),
        .mode_q (mode_q),
        .done   (done)
    );

    assign pass = done && (mode_q == MODE_CHK) && (crc_out == '0);

    a_r8_pass_in_check_only: assert property (@(posedge clk) disable iff (rst)
        pass |-> (done && crc_out == '0));

    a_r6_frozen_after_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(crc_out));

    a_r9_start_beats_bit: assert property (@(posedge clk) disable iff (rst)
        (start && in_valid) |=> (crc_out == '0 && !done));

endmodule

// File: tb/tb_crc3_serial_unit.sv
module tb_crc3_serial_unit;

    logic       clk = 1'b0;
    logic       rst, start, mode, in_valid, in_bit;
    logic [2:0] crc_out;
    logic       done, pass;

    always #10 clk = ~clk;

    crc3_serial_unit dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .in_valid(in_valid), .in_bit(in_bit),
        .crc_out(crc_out), .done(done), .pass(pass)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model
    int         m_bits[0:16];
    int         m_n = 0;
    int         m_mode = 0;
    logic [2:0] e_crc = 3'b000;
    logic       e_done = 1'b0;
    logic       e_pass = 1'b0;

    function automatic logic [2:0] ref_rem(int nb);
        logic [19:0] v;
        v = '0;
        for (int i = 0; i < nb; i++) v = (v << 1) | 20'(m_bits[i]);
        v = v << 3;
        for (int i = nb + 2; i >= 3; i--)
            if (v[i]) v[i -: 4] = v[i -: 4] ^ 4'b1011;
        return v[2:0];
    endfunction

    function automatic int limit_of(int md);
        return md ? 17 : 14;
    endfunction

    task automatic check(string req, string what, logic [2:0] act, logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur_req, "crc_out", crc_out, e_crc);
        check(cur_req, "done", {2'b0, done}, {2'b0, e_done});
        check(cur_req, "pass", {2'b0, pass}, {2'b0, e_pass});
    endtask

    // called at a negedge: compare, drive, advance model to next edge
    task automatic cyc(logic r, logic s, logic md, logic v, logic b);
        compare_all();
        rst = r; start = s; mode = md; in_valid = v; in_bit = b;
        if (r) begin
            m_n = 0; m_mode = 0;
        end else if (s) begin
            m_n = 0; m_mode = int'(md);
        end else if (v && m_n < limit_of(m_mode)) begin
            m_bits[m_n] = int'(b);
            m_n++;
        end
        e_crc  = ref_rem(m_n);
        e_done = (m_n == limit_of(m_mode));
        e_pass = e_done && (m_mode == 1) && (e_crc == 3'b000);
        @(negedge clk);
    endtask

    task automatic feed(logic [16:0] word, int len, logic md, int gap);
        for (int i = len - 1; i >= 0; i--) begin
            cyc(0, 0, ~md, 1, word[i]);   // mode toggled: must be ignored (R3)
            for (int g = 0; g < gap; g++) cyc(0, 0, md, 0, ~word[i]);
        end
    endtask

    logic [13:0] msg;
    logic [2:0]  gen_crc;

    initial begin
        rst = 1; start = 0; mode = 0; in_valid = 0; in_bit = 0;
        @(negedge clk);
        cur_req = "R1";
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        // known message
        cur_req = "R2";
        cyc(0, 1, 0, 0, 0);
        feed(17'b11010011101100, 14, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check("R2", "known remainder", crc_out, 3'b100);
        check("R5", "done after 14", {2'b0, done}, 3'b001);

        // extra bits after done are discarded
        cur_req = "R6";
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 1);
        check("R6", "crc kept after done", crc_out, 3'b100);

        // gaps in valid
        cur_req = "R4";
        cyc(0, 1, 0, 0, 0);
        feed(17'b11010011101100, 14, 0, 2);
        cyc(0, 0, 0, 0, 0);
        check("R4", "remainder with gaps", crc_out, 3'b100);

        // check mode, good frame
        cur_req = "R7";
        cyc(0, 1, 1, 0, 0);
        feed(17'b11010011101100100, 17, 1, 0);
        cyc(0, 0, 1, 0, 0);
        check("R7", "pass good frame", {2'b0, pass}, 3'b001);
        check("R5", "done after 17", {2'b0, done}, 3'b001);

        // check mode, corrupted frame
        cur_req = "R8";
        cyc(0, 1, 1, 0, 0);
        feed(17'b11010011101101100, 17, 1, 1);
        cyc(0, 0, 1, 0, 0);
        check("R8", "pass low on bad frame", {2'b0, pass}, 3'b000);

        // start and valid together mid-frame
        cur_req = "R9";
        cyc(0, 1, 0, 0, 0);
        feed(17'b10110, 5, 0, 0);
        cyc(0, 1, 0, 1, 1);
        cyc(0, 0, 0, 0, 0);
        check("R9", "cleared by start", crc_out, 3'b000);
        feed(17'b11010011101100, 14, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check("R9", "full count after start", crc_out, 3'b100);

        // random messages: generate then check
        for (int k = 0; k < 20; k++) begin
            msg = 14'($urandom);
            cur_req = "R2";
            cyc(0, 1, 0, 0, 0);
            feed({3'b0, msg}, 14, 0, k % 3);
            cyc(0, 0, 0, 0, 0);
            gen_crc = crc_out;
            cur_req = "R7";
            cyc(0, 1, 1, 0, 0);
            feed({msg, gen_crc}, 17, 1, 0);
            cyc(0, 0, 1, 0, 0);
            check("R7", "pass on generated frame", {2'b0, pass}, 3'b001);
            cur_req = "R3";
            cyc(0, 1, 0, 0, 0);
            check("R3", "start clears", crc_out, 3'b000);
        end

        cur_req = "R1";
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        compare_all();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule